// File: doc/BRIEF.md
# Context-Tagged Page Translation Cache

This block holds page translations in on-chip storage that is split into one table per software context. A lookup names a context number, an 8-bit virtual page, a byte offset and an access kind. One cycle later the block answers with a hit, a miss or a permission fault. On a hit it also returns the physical address, which is a 12-bit physical page joined to the 8-bit offset to give 20 bits. A task switch only changes the context number that the requester drives, so no table has to be reloaded.

Each entry has a valid bit. A miss tells an external page-table walker to fetch the translation from memory. The walker then writes its result back through the refill port, and that refill marks the entry valid. Each entry also carries three attribute bits: read-only, no-execute and not-mapped. An invalidate command clears every entry of one context, one entry per clock, and holds a busy flag for the whole sweep. The default size has 8 contexts. Setting `CTX_W` to 7 gives 128 contexts.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `rs_valid` is low and `inv_busy` is low.
- R2: `rs_valid` is high in exactly the cycle after a cycle with `lk_req` high. While it is high, exactly one of `rs_hit`, `rs_miss`, `rs_fault` is high. While it is low, all three are low.
- R3: A lookup of an invalid entry reports `rs_miss`, and `rs_paddr` is 0.
- R4: A lookup of a valid entry whose attributes allow the access reports `rs_hit`, and `rs_paddr` equals {stored physical page, `lk_off`}.
- R5: A refill accepted at a clock edge writes the physical page and attributes to entry {`rf_ctx`, `rf_vpn`} and sets it valid. A lookup of the same entry at that same edge still sees the old contents.
- R6: Entries are tagged by context. A refill or an invalidate in one context leaves the entry with the same virtual page in every other context unchanged.
- R7: `lk_kind` uses 00 for a data read, 01 for a data write, 10 for an opcode fetch, and 11 for a data read. A write to a valid entry that has `ro` set reports `rs_fault`.
- R8: An opcode fetch from a valid entry that has `nx` set reports `rs_fault`. A data read of that entry is a hit.
- R9: A valid entry that has `nm` set reports `rs_fault` for every access kind. On a fault `rs_paddr` is 0.
- R10: When `inv_start` is high while the block is idle, `inv_busy` goes high from the next cycle for exactly 2^8 = 256 cycles. Afterwards every entry of `inv_ctx` is invalid.
- R11: While `inv_busy` is high, the block ignores `rf_we` and `inv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_ctx | input | CTX_W | Lookup context number |
| lk_vpn | input | 8 | Lookup virtual page |
| lk_off | input | 8 | Byte offset within the page |
| lk_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch, 11 read) |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation hit |
| rs_miss | output | 1 | Entry invalid; walk needed |
| rs_fault | output | 1 | Permission fault |
| rs_paddr | output | 20 | Physical address on hit, else 0 |
| rf_we | input | 1 | Refill write |
| rf_ctx | input | CTX_W | Refill context |
| rf_vpn | input | 8 | Refill virtual page |
| rf_ppn | input | 12 | Refill physical page |
| rf_ro | input | 1 | Refill read-only attribute |
| rf_nx | input | 1 | Refill no-execute attribute |
| rf_nm | input | 1 | Refill not-mapped attribute |
| inv_start | input | 1 | Start invalidating one context |
| inv_ctx | input | CTX_W | Context to invalidate |
| inv_busy | output | 1 | Invalidate sweep in progress |

## Verification
The properties assume that the reset is synchronous and is held for at least one edge. They make no assumption about how often `lk_req` is raised. They allow a refill in any cycle, including the cycle that looks up the same entry.

The stimulus draws contexts freely and keeps virtual pages in a narrow range, so that refills and lookups often meet on the same entry. It issues invalidate commands only in directed phases. During those phases it sends no lookups. It raises `rf_we` and `inv_start` during a sweep only to confirm that they are ignored.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

    localparam int VPN_W  = 8;
    localparam int OFF_W  = 8;
    localparam int PPN_W  = 12;
    localparam int PA_W   = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_READ2 = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             ro;
        logic             nx;
        logic             nm;
    } xlat_entry_t;

    localparam int ENTRY_W = $bits(xlat_entry_t);

    typedef enum logic [1:0] {
        VERD_MISS  = 2'b00,
        VERD_HIT   = 2'b01,
        VERD_FAULT = 2'b10
    } verdict_e;

    function automatic verdict_e judge(input logic vld, input xlat_entry_t e,
                                       input acc_kind_e k);
        verdict_e v;
        if (!vld)
            v = VERD_MISS;
        else if (e.nm)
            v = VERD_FAULT;
        else if (k == ACC_WRITE && e.ro)
            v = VERD_FAULT;
        else if (k == ACC_FETCH && e.nx)
            v = VERD_FAULT;
        else
            v = VERD_HIT;
        return v;
    endfunction

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
    parameter int AW = 11,
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/xlat_valid_bits.sv
module xlat_valid_bits #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic          rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] vbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbits <= '0;
            rd_q  <= 1'b0;
        end else begin
            if (set_en)
                vbits[set_idx] <= 1'b1;
            if (clr_en)
                vbits[clr_idx] <= 1'b0;
            if (rd_en)
                rd_q <= vbits[rd_idx];
        end
    end
endmodule

// File: rtl/xlat_inval_seq.sv
module xlat_inval_seq #(
    parameter int CTX_W = 3,
    parameter int VPN_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CTX_W-1:0]       ctx,
    output logic                   busy,
    output logic                   clr_en,
    output logic [CTX_W+VPN_W-1:0] clr_idx
);
    localparam logic [VPN_W-1:0] LAST = {VPN_W{1'b1}};

    logic             busy_q;
    logic [CTX_W-1:0] ctx_q;
    logic [VPN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctx_q  <= '0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                ctx_q  <= ctx;
                cnt_q  <= '0;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
                busy_q <= 1'b0;
        end
    end

    assign busy    = busy_q;
    assign clr_en  = busy_q;
    assign clr_idx = {ctx_q, cnt_q};
endmodule

// File: rtl/xlat_perm_eval.sv
module xlat_perm_eval
    import xlat_cache_pkg::*;
(
    input  logic              req,
    input  logic              vld,
    input  xlat_entry_t       ent,
    input  acc_kind_e         kind,
    input  logic [OFF_W-1:0]  off,
    output logic              hit,
    output logic              miss,
    output logic              fault,
    output logic [PA_W-1:0]   paddr
);
    verdict_e v;

    always_comb begin
        v     = judge(vld, ent, kind);
        hit   = req && (v == VERD_HIT);
        miss  = req && (v == VERD_MISS);
        fault = req && (v == VERD_FAULT);
        paddr = hit ? {ent.ppn, off} : '0;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int CTX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_req,
    input  logic [CTX_W-1:0]     lk_ctx,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [OFF_W-1:0]     lk_off,
    input  logic [1:0]           lk_kind,
    output logic                 rs_valid,
    output logic                 rs_hit,
    output logic                 rs_miss,
    output logic                 rs_fault,
    output logic [PA_W-1:0]      rs_paddr,
    input  logic                 rf_we,
    input  logic [CTX_W-1:0]     rf_ctx,
    input  logic [VPN_W-1:0]     rf_vpn,
    input  logic [PPN_W-1:0]     rf_ppn,
    input  logic                 rf_ro,
    input  logic                 rf_nx,
    input  logic                 rf_nm,
    input  logic                 inv_start,
    input  logic [CTX_W-1:0]     inv_ctx,
    output logic                 inv_busy
);
    localparam int IDX_W = CTX_W + VPN_W;

    logic             req_q;
    acc_kind_e        kind_q;
    logic [OFF_W-1:0] off_q;

    logic             rf_acc;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    xlat_entry_t      wr_ent;
    xlat_entry_t      rd_ent;
    logic [ENTRY_W-1:0] rd_raw;
    logic             rd_vld;

    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;

    assign rf_acc = rf_we && !inv_busy;
    assign rd_idx = {lk_ctx, lk_vpn};
    assign wr_idx = {rf_ctx, rf_vpn};

    always_comb begin
        wr_ent.ppn = rf_ppn;
        wr_ent.ro  = rf_ro;
        wr_ent.nx  = rf_nx;
        wr_ent.nm  = rf_nm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            kind_q <= ACC_READ;
            off_q  <= '0;
        end else begin
            req_q <= lk_req;
            if (lk_req) begin
                kind_q <= acc_kind_e'(lk_kind);
                off_q  <= lk_off;
            end
        end
    end

    xlat_entry_store #(.AW(IDX_W), .DW(ENTRY_W)) u_store (
        .clk   (clk),
        .we    (rf_acc),
        .waddr (wr_idx),
        .wdata (wr_ent),
        .re    (lk_req),
        .raddr (rd_idx),
        .rdata (rd_raw)
    );

    assign rd_ent = xlat_entry_t'(rd_raw);

    xlat_valid_bits #(.AW(IDX_W)) u_valid (
        .clk     (clk),
        .rst     (rst),
        .set_en  (rf_acc),
        .set_idx (wr_idx),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_en   (lk_req),
        .rd_idx  (rd_idx),
        .rd_q    (rd_vld)
    );

    xlat_inval_seq #(.CTX_W(CTX_W), .VPN_W(VPN_W)) u_inval (
        .clk     (clk),
        .rst     (rst),
        .start   (inv_start),
        .ctx     (inv_ctx),
        .busy    (inv_busy),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    xlat_perm_eval u_eval (
        .req   (req_q),
        .vld   (rd_vld),
        .ent   (rd_ent),
        .kind  (kind_q),
        .off   (off_q),
        .hit   (rs_hit),
        .miss  (rs_miss),
        .fault (rs_fault),
        .paddr (rs_paddr)
    );

    assign rs_valid = req_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_cache_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_req,
    input logic            rs_valid,
    input logic            rs_hit,
    input logic            rs_miss,
    input logic            rs_fault,
    input logic [PA_W-1:0] rs_paddr,
    input logic            inv_start,
    input logic            inv_busy
);
    localparam int SWEEP = 1 << VPN_W;

    logic [VPN_W:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            busy_cnt <= '0;
        else if (inv_busy)
            busy_cnt <= busy_cnt + 1'b1;
        else
            busy_cnt <= '0;
    end

    assert_result_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rs_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rs_valid);

    assert_one_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |-> !(rs_hit || rs_miss || rs_fault));

    assert_paddr_zero_off_hit_R9: assert property (@(posedge clk) disable iff (rst)
        !rs_hit |-> rs_paddr == '0);

    assert_sweep_starts_R10: assert property (@(posedge clk) disable iff (rst)
        (inv_start && !inv_busy) |=> inv_busy);

    assert_sweep_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        inv_busy |-> busy_cnt < SWEEP);

    assert_sweep_length_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(inv_busy) |-> busy_cnt == SWEEP);
endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .rs_valid  (rs_valid),
    .rs_hit    (rs_hit),
    .rs_miss   (rs_miss),
    .rs_fault  (rs_fault),
    .rs_paddr  (rs_paddr),
    .inv_start (inv_start),
    .inv_busy  (inv_busy)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CTX_W = 3;
    localparam int NENT = 1 << (CTX_W + 8);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_req = 1'b0;
    logic [CTX_W-1:0] lk_ctx = '0;
    logic [7:0] lk_vpn = '0, lk_off = '0;
    logic [1:0] lk_kind = '0;
    logic rs_valid, rs_hit, rs_miss, rs_fault;
    logic [19:0] rs_paddr;
    logic rf_we = 1'b0;
    logic [CTX_W-1:0] rf_ctx = '0;
    logic [7:0] rf_vpn = '0;
    logic [11:0] rf_ppn = '0;
    logic rf_ro = 1'b0, rf_nx = 1'b0, rf_nm = 1'b0;
    logic inv_start = 1'b0;
    logic [CTX_W-1:0] inv_ctx = '0;
    logic inv_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache #(.CTX_W(CTX_W)) u_xlat_cache (.*);

    // reference model
    logic        m_vld [NENT];
    logic [14:0] m_ent [NENT];   // {ppn, ro, nx, nm}

    int n_chk = 0;
    int n_bad = 0;
    logic        pend = 1'b0;
    logic [23:0] pend_exp;        // {hit, miss, fault, 1'b0, paddr}
    string       pend_tag;

    function automatic logic [23:0] expect_of(input int idx, input logic [1:0] k,
                                              input logic [7:0] off);
        logic [14:0] e;
        e = m_ent[idx];
        if (!m_vld[idx])                    return {4'b0100, 20'd0};
        if (e[0])                           return {4'b0010, 20'd0};
        if (k == 2'b01 && e[2])             return {4'b0010, 20'd0};
        if (k == 2'b10 && e[1])             return {4'b0010, 20'd0};
        return {4'b1000, e[14:3], off};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: check prior result at this negedge, then drive new inputs
    task automatic cycle(input logic do_lk, input int lctx, input int lvpn,
                         input logic [1:0] lkind, input logic [7:0] loff,
                         input logic do_rf, input int fctx, input int fvpn,
                         input logic [11:0] fppn, input logic [2:0] fatt,
                         input string tag);
        @(negedge clk);
        if (pend)
            check({pend_tag, " R2/result"},
                  {8'd0, rs_hit, rs_miss, rs_fault, 1'b0, rs_paddr},
                  {8'd0, pend_exp});
        else
            check("R2 idle", {31'd0, rs_valid}, 32'd0);
        lk_req  = do_lk;
        lk_ctx  = CTX_W'(lctx);
        lk_vpn  = 8'(lvpn);
        lk_kind = lkind;
        lk_off  = loff;
        rf_we   = do_rf;
        rf_ctx  = CTX_W'(fctx);
        rf_vpn  = 8'(fvpn);
        rf_ppn  = fppn;
        {rf_ro, rf_nx, rf_nm} = fatt;
        pend     = do_lk;
        pend_tag = tag;
        if (do_lk) pend_exp = expect_of(lctx*256 + lvpn, lkind, loff);
        if (do_rf && !inv_busy) begin
            m_vld[fctx*256 + fvpn] = 1'b1;
            m_ent[fctx*256 + fvpn] = {fppn, fatt};
        end
    endtask

    task automatic look(input int c, input int v, input logic [1:0] k, input string tag);
        cycle(1'b1, c, v, k, 8'h5A, 1'b0, 0, 0, 12'd0, 3'd0, tag);
    endtask

    task automatic fill(input int c, input int v, input logic [11:0] p, input logic [2:0] a);
        cycle(1'b0, 0, 0, 2'b00, 8'd0, 1'b1, c, v, p, a, "R5 fill");
    endtask

    initial begin
        int busy_cycles;
        for (int i = 0; i < NENT; i++) begin m_vld[i] = 1'b0; m_ent[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R1 rs_valid", {31'd0, rs_valid}, 32'd0);
        check("R1 inv_busy", {31'd0, inv_busy}, 32'd0);
        look(0, 0, 2'b00, "R1 empty");
        look(7, 255, 2'b10, "R1 R3 empty");

        // R5: same-edge refill and lookup sees old, next sees new
        cycle(1'b1, 1, 10, 2'b00, 8'h33, 1'b1, 1, 10, 12'hABC, 3'b000, "R5 old");
        look(1, 10, 2'b00, "R5 R4 new");
        // R6: same vpn in other context untouched
        look(2, 10, 2'b00, "R6 other ctx");
        // R7 / R8 / R9
        fill(1, 20, 12'h111, 3'b100);
        look(1, 20, 2'b01, "R7 write ro");
        look(1, 20, 2'b00, "R7 read ro");
        look(1, 20, 2'b11, "R7 kind11 read");
        fill(1, 21, 12'h222, 3'b010);
        look(1, 21, 2'b10, "R8 fetch nx");
        look(1, 21, 2'b00, "R8 read nx");
        fill(1, 22, 12'h333, 3'b001);
        look(1, 22, 2'b00, "R9 nm read");
        look(1, 22, 2'b01, "R9 nm write");
        look(1, 22, 2'b10, "R9 nm fetch");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int lc, lv, fc, fv;
            lc = $urandom % 8; lv = $urandom % 12;
            fc = $urandom % 8; fv = $urandom % 12;
            cycle(($urandom % 4) != 0, lc, lv, 2'($urandom), 8'($urandom),
                  ($urandom % 5) < 2, fc, fv, 12'($urandom), 3'($urandom % 8),
                  "R3 R4 R7 R8 R9 random");
        end

        // R10 / R11: invalidate context 2
        fill(2, 5, 12'h0F0, 3'b000);
        fill(3, 5, 12'h0F1, 3'b000);
        cycle(1'b0, 0, 0, 2'b00, 8'd0, 1'b0, 0, 0, 12'd0, 3'd0, "idle");
        inv_start = 1'b1; inv_ctx = 3'd2;
        @(negedge clk);
        check("R2 idle", {31'd0, rs_valid}, 32'd0);
        pend = 1'b0;
        inv_start = 1'b0;
        for (int i = 0; i < 256; i++) m_vld[2*256 + i] = 1'b0;
        check("R10 busy rises", {31'd0, inv_busy}, 32'd1);
        busy_cycles = 1;
        // R11 attempts while busy
        rf_we = 1'b1; rf_ctx = 3'd4; rf_vpn = 8'd9; rf_ppn = 12'h777;
        inv_start = 1'b1; inv_ctx = 3'd3;
        @(negedge clk);
        rf_we = 1'b0; inv_start = 1'b0;
        while (inv_busy && busy_cycles < 400) begin
            busy_cycles++;
            @(negedge clk);
        end
        check("R10 busy length", busy_cycles, 256);
        look(2, 5, 2'b00, "R10 ctx cleared");
        look(2, 10, 2'b00, "R10 ctx cleared");
        look(3, 5, 2'b00, "R6 R11 ctx kept");
        look(4, 9, 2'b00, "R11 refill dropped");
        look(1, 10, 2'b00, "R6 other ctx kept");
        cycle(1'b0, 0, 0, 2'b00, 8'd0, 1'b0, 0, 0, 12'd0, 3'd0, "tail");
        cycle(1'b0, 0, 0, 2'b00, 8'd0, 1'b0, 0, 0, 12'd0, 3'd0, "tail");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule